// File: doc/BRIEF.md
# Interrupt Priority and Acknowledge Sequencer

This block sits next to a small 8-bit processor core. Each time the core signals that an instruction has finished, the block looks at the pending interrupt sources and picks one. The sources are a non-maskable pin, a maskable line that supplies a vector over the data bus (INT0), and two internal maskable requests (INT1, INT2). The block then runs the acknowledge bus cycle for that source. When the cycle ends, it reports the source and the next program address on a one-cycle completion pulse.

The block holds the interrupt-enable flag. The core can write this flag when the block is idle. The block clears it when servicing begins. When the non-maskable source is serviced, the flag's previous value is copied into a shadow bit. The block never drives the memory-request or read strobe during an acknowledge, so an acknowledge cannot be mistaken for an opcode fetch.

The controller has four states:
- IDLE waits for the end-of-instruction strobe.
- ACK_VEC is the INT0 acknowledge, with both strobes low.
- ACK_SILENT is the acknowledge for the non-maskable source, INT1 and INT2, with no strobe asserted.
- DONE raises the completion pulse.

The transitions are:
- IDLE→ACK_VEC when INT0 wins.
- IDLE→ACK_SILENT when any other source wins.
- ACK_VEC or ACK_SILENT→DONE after `ACK_CYC` clocks.
- DONE→IDLE after one clock.

Top module: `irq_ack_seq`

## Requirements
- R1: A falling edge on `nmi_n` is held pending even if the pin returns high before the next end-of-instruction strobe, and it is serviced at that strobe.
- R2: A pending non-maskable request is serviced whatever the value of the enable flag.
- R3: When the non-maskable request and any maskable request are pending at the same boundary, the non-maskable request is serviced.
- R4: The non-maskable service reports source code 0 and address 0x0066. It leaves the enable flag at 0 and copies the flag's previous value to `ie_save_o`.
- R5: When the enable flag is 0 and nothing non-maskable is pending, an end-of-instruction strobe starts no service, even with maskable requests present.
- R6: Maskable priority is INT0 (source code 1) over INT1 (code 2) over INT2 (code 3).
- R7: The INT0 acknowledge holds `m1_n` and `iorq_n` low together for exactly `ACK_CYC` clocks, beginning the clock after the strobe. `mreq_n` and `rd_n` stay high throughout.
- R8: The INT1, INT2 and non-maskable acknowledges last `ACK_CYC` clocks (`busy` high) with `m1_n` and `iorq_n` both high.
- R9: For INT0, the byte on `data_in` during the last strobe clock is reported as `done_addr` = {8'h00, byte}. INT1 and INT2 report address 0.
- R10: Starting any service clears the enable flag.
- R11: The pending non-maskable latch clears when its acknowledge begins. A falling edge that arrives during another service is kept for the next boundary.
- R12: `done` is a single-clock pulse, raised once per service in the clock after the acknowledge ends. Without an end-of-instruction strobe, the block stays idle.
- R13: An end-of-instruction strobe that arrives while an acknowledge is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_n | input | 1 | Non-maskable request, falling-edge triggered |
| int0_req | input | 1 | Maskable request with data-bus vector |
| int1_req | input | 1 | Internal maskable request 1 |
| int2_req | input | 1 | Internal maskable request 2 |
| ie_we | input | 1 | Core write strobe for the enable flag |
| ie_wd | input | 1 | Value written to the enable flag |
| eoi | input | 1 | End-of-instruction strobe |
| data_in | input | DW | Data bus, vector source for INT0 |
| m1_n | output | 1 | Active-low machine-cycle-one strobe |
| iorq_n | output | 1 | Active-low I/O request strobe |
| mreq_n | output | 1 | Active-low memory request, always inactive here |
| rd_n | output | 1 | Active-low read strobe, always inactive here |
| busy | output | 1 | Acknowledge cycle in progress |
| ie_o | output | 1 | Current enable flag |
| ie_save_o | output | 1 | Shadow copy of the flag taken at non-maskable service |
| done | output | 1 | One-cycle completion pulse |
| done_src | output | 2 | Serviced source code, valid with `done` |
| done_addr | output | AW | Vector or target address, valid with `done` |

## Verification
The hardest case to reach is a non-maskable edge that lands while another acknowledge is already running. The same applies to a stray end-of-instruction strobe inside that window. The stimulus forks a pin pulse, and where needed an extra strobe, at fixed clock offsets into an INT0 or INT1 acknowledge. It then checks that no second service starts early. It also checks that the held edge is serviced at the following boundary, with the enable flag already cleared, so that R2 and R11 are confirmed together.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

    typedef enum logic [1:0] {
        SRC_NMI  = 2'd0,
        SRC_INT0 = 2'd1,
        SRC_INT1 = 2'd2,
        SRC_INT2 = 2'd3
    } irq_src_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACK_VEC,
        ST_ACK_SILENT,
        ST_DONE
    } ack_state_e;

    localparam int N_MASKABLE = 3;

endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic clr,
    output logic pend
);
    logic prev_q;
    logic fall;

    assign fall = prev_q & ~nmi_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            pend   <= 1'b0;
        end else begin
            prev_q <= nmi_n;
            if (fall)
                pend <= 1'b1;
            else if (clr)
                pend <= 1'b0;
        end
    end

    // R11
    nmi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> pend);

    // R1
    nmi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(nmi_n) && !nmi_n) |=> pend);

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_ack_pkg::*;
(
    input  logic                  nmi_pend,
    input  logic                  ie,
    input  logic [N_MASKABLE-1:0] mreq,
    output logic                  vld,
    output irq_src_e              src
);
    always_comb begin
        vld = nmi_pend | (ie & (|mreq));
        src = SRC_NMI;
        if (!nmi_pend) begin
            for (int i = N_MASKABLE - 1; i >= 0; i--) begin
                if (ie && mreq[i])
                    src = irq_src_e'(i + 1);
            end
        end
    end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
    import irq_ack_pkg::*;
#(
    parameter int              ACK_CYC    = 3,
    parameter int              AW         = 16,
    parameter int              DW         = 8,
    parameter logic [AW-1:0]   NMI_TARGET = 16'h0066
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nmi_n,
    input  logic          int0_req,
    input  logic          int1_req,
    input  logic          int2_req,
    input  logic          ie_we,
    input  logic          ie_wd,
    input  logic          eoi,
    input  logic [DW-1:0] data_in,
    output logic          m1_n,
    output logic          iorq_n,
    output logic          mreq_n,
    output logic          rd_n,
    output logic          busy,
    output logic          ie_o,
    output logic          ie_save_o,
    output logic          done,
    output logic [1:0]    done_src,
    output logic [AW-1:0] done_addr
);
    localparam int CW = (ACK_CYC > 1) ? $clog2(ACK_CYC) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(ACK_CYC - 1);

    ack_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    irq_src_e      src_q;
    logic [DW-1:0] vec_q;
    logic          ie_q, save_q;

    logic          nmi_pend;
    logic          pick_vld;
    irq_src_e      pick_src;
    logic          start;
    logic          last;
    logic          in_ack;

    irq_nmi_latch u_nmi (
        .clk   (clk),
        .rst_n (rst_n),
        .nmi_n (nmi_n),
        .clr   (start && (pick_src == SRC_NMI)),
        .pend  (nmi_pend)
    );

    irq_prio_pick u_pick (
        .nmi_pend (nmi_pend),
        .ie       (ie_q),
        .mreq     ({int2_req, int1_req, int0_req}),
        .vld      (pick_vld),
        .src      (pick_src)
    );

    assign start  = (state_q == ST_IDLE) && eoi && pick_vld;
    assign in_ack = (state_q == ST_ACK_VEC) || (state_q == ST_ACK_SILENT);
    assign last   = in_ack && (cnt_q == LAST_CNT);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start) state_d = (pick_src == SRC_INT0) ? ST_ACK_VEC : ST_ACK_SILENT;
            ST_ACK_VEC:    if (last)  state_d = ST_DONE;
            ST_ACK_SILENT: if (last)  state_d = ST_DONE;
            ST_DONE:                  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            src_q  <= SRC_NMI;
            vec_q  <= '0;
            ie_q   <= 1'b0;
            save_q <= 1'b0;
        end else begin
            if (start)
                cnt_q <= '0;
            else if (in_ack)
                cnt_q <= cnt_q + 1'b1;
            if (start) begin
                src_q <= pick_src;
                ie_q  <= 1'b0;
                if (pick_src == SRC_NMI)
                    save_q <= ie_q;
            end else if (ie_we) begin
                ie_q <= ie_wd;
            end
            if ((state_q == ST_ACK_VEC) && last)
                vec_q <= data_in;
        end
    end

    // outputs
    always_comb begin
        m1_n      = 1'b1;
        iorq_n    = 1'b1;
        busy      = 1'b0;
        done      = 1'b0;
        done_addr = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ACK_VEC: begin
                m1_n   = 1'b0;
                iorq_n = 1'b0;
                busy   = 1'b1;
            end
            ST_ACK_SILENT: busy = 1'b1;
            ST_DONE: begin
                done = 1'b1;
                if (src_q == SRC_NMI)
                    done_addr = NMI_TARGET;
                else if (src_q == SRC_INT0)
                    done_addr = AW'(vec_q);
            end
        endcase
    end

    assign mreq_n    = 1'b1;
    assign rd_n      = 1'b1;
    assign done_src  = src_q;
    assign ie_o      = ie_q;
    assign ie_save_o = save_q;

    // R7
    strobe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(m1_n) |-> $past(eoi));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ie_o);

    // R5
    masked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && eoi && !ie_q && !nmi_pend) |=> (state_q == ST_IDLE));

    // R13
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eoi) |=> (state_q != ST_IDLE));

endmodule

// File: tb/irq_ack_seq_test.sv
`timescale 1ns/1ps
module irq_ack_seq_test;
    localparam int ACK = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nmi_n = 1'b1;
    logic int0_req = 1'b0, int1_req = 1'b0, int2_req = 1'b0;
    logic ie_we = 1'b0, ie_wd = 1'b0, eoi = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic m1_n, iorq_n, mreq_n, rd_n, busy, ie_o, ie_save_o, done;
    logic [1:0] done_src;
    logic [15:0] done_addr;

    int checks = 0;
    int errors = 0;

    typedef struct { logic [1:0] src; logic [15:0] addr; } exp_t;
    exp_t exp_q[$];
    exp_t mon_e;

    always #2 clk = ~clk;

    irq_ack_seq uut (
        .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n),
        .int0_req(int0_req), .int1_req(int1_req), .int2_req(int2_req),
        .ie_we(ie_we), .ie_wd(ie_wd), .eoi(eoi), .data_in(data_in),
        .m1_n(m1_n), .iorq_n(iorq_n), .mreq_n(mreq_n), .rd_n(rd_n),
        .busy(busy), .ie_o(ie_o), .ie_save_o(ie_save_o), .done(done),
        .done_src(done_src), .done_addr(done_addr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // monitor: compares each completion against the scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R12 unexpected done actual src=%0d expected none", done_src);
            end else begin
                mon_e = exp_q.pop_front();
                if (done_src !== mon_e.src || done_addr !== mon_e.addr) begin
                    errors++;
                    $display("FAIL R6/R9 done actual=%0d/%04h expected=%0d/%04h",
                             done_src, done_addr, mon_e.src, mon_e.addr);
                end
            end
        end
    end

    task automatic set_ie(input logic v);
        @(negedge clk) begin ie_we = 1'b1; ie_wd = v; end
        @(negedge clk) ie_we = 1'b0;
    endtask

    // driver: push expectation, pulse eoi, watch the acknowledge strobes
    task automatic do_ack(input logic [1:0] s, input logic [15:0] a,
                          input int exp_low, input string req);
        int lows, bsy, bad;
        lows = 0; bsy = 0; bad = 0;
        exp_q.push_back('{s, a});
        @(negedge clk) eoi = 1'b1;
        @(negedge clk) eoi = 1'b0;
        for (int i = 0; i < 20 && !done; i++) begin
            if (!m1_n) lows++;
            if (m1_n !== iorq_n) bad++;
            if (!mreq_n || !rd_n) bad++;
            if (busy) bsy++;
            @(negedge clk);
        end
        chk(lows == exp_low, {req, " R7 strobe clocks"}, lows, exp_low);
        chk(bsy == ACK, {req, " R8 ack length"}, bsy, ACK);
        chk(bad == 0, {req, " R7 strobe pairing/mreq/rd"}, bad, 0);
    endtask

    task automatic idle_window(input string req);
        int nb;
        nb = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (busy || done) nb++;
        end
        chk(nb == 0, req, nb, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(m1_n && iorq_n && mreq_n && rd_n && !busy && !done && !ie_o,
            "R12 reset state", {m1_n, iorq_n, busy, done, ie_o}, 5'b11000);

        // R12: requests present, no strobe -> idle
        set_ie(1'b1);
        int0_req = 1'b1;
        idle_window("R12 no eoi stays idle");
        set_ie(1'b0);

        // R5: masked
        @(negedge clk) eoi = 1'b1;
        @(negedge clk) eoi = 1'b0;
        idle_window("R5 masked request ignored");
        chk(ie_o == 1'b0, "R5 flag unchanged", ie_o, 0);

        // R6 R7 R9 R10: all maskable high -> INT0 wins
        set_ie(1'b1);
        int1_req = 1'b1; int2_req = 1'b1; data_in = 8'hA5;
        do_ack(2'd1, 16'h00A5, ACK, "R6");
        chk(ie_o == 1'b0, "R10 flag cleared", ie_o, 0);

        // R6 R8: INT1 over INT2
        int0_req = 1'b0;
        set_ie(1'b1);
        do_ack(2'd2, 16'h0000, 0, "R8 int1");
        int1_req = 1'b0;
        set_ie(1'b1);
        do_ack(2'd3, 16'h0000, 0, "R8 int2");
        int2_req = 1'b0;

        // R1 R3 R4: short pulse, then compete with INT0
        @(negedge clk) nmi_n = 1'b0;
        @(negedge clk) nmi_n = 1'b1;
        repeat (3) @(negedge clk);
        set_ie(1'b1);
        int0_req = 1'b1;
        do_ack(2'd0, 16'h0066, 0, "R3");
        chk(ie_o == 1'b0, "R4 flag cleared", ie_o, 0);
        chk(ie_save_o == 1'b1, "R4 shadow copy", ie_save_o, 1);
        int0_req = 1'b0;

        // R2: flag clear, still serviced
        @(negedge clk) nmi_n = 1'b0;
        @(negedge clk) nmi_n = 1'b1;
        do_ack(2'd0, 16'h0066, 0, "R2");
        chk(ie_save_o == 1'b0, "R2 shadow copy", ie_save_o, 0);

        // R11: edge during INT0 service kept for next boundary
        set_ie(1'b1);
        int0_req = 1'b1; data_in = 8'h3C;
        fork
            do_ack(2'd1, 16'h003C, ACK, "R11 int0");
            begin
                @(negedge clk); @(negedge clk);
                nmi_n = 1'b0;
                @(negedge clk) nmi_n = 1'b1;
            end
        join
        int0_req = 1'b0;
        do_ack(2'd0, 16'h0066, 0, "R11 held edge");
        @(negedge clk) eoi = 1'b1;
        @(negedge clk) eoi = 1'b0;
        idle_window("R11 latch cleared at acknowledge");

        // R13: stray strobe mid-service ignored
        set_ie(1'b1);
        int1_req = 1'b1;
        fork
            do_ack(2'd2, 16'h0000, 0, "R13 int1");
            begin
                @(negedge clk); @(negedge clk);
                nmi_n = 1'b0;
                @(negedge clk) begin nmi_n = 1'b1; eoi = 1'b1; end
                @(negedge clk) eoi = 1'b0;
            end
        join
        int1_req = 1'b0;
        idle_window("R13 stray strobe started nothing");
        do_ack(2'd0, 16'h0066, 0, "R13 pending after");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R12 all completions seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule